// File: doc/BRIEF.md
# Indirectly Addressed Interrupt Redirection Controller

This block routes a small set of interrupt input pins to a single outgoing message channel. Each pin has its own 64-bit redirection entry. The entry sets the vector, delivery mode, destination mode, destination, polarity, trigger style and mask for that pin. Software sees only two 32-bit locations on the bus. One is a selector that picks an internal register. The other is a window that reads or writes the register the selector points at.

Inputs are sampled on the block clock and treated as edge or level events after polarity correction. Edge events are latched until they are delivered. A level input raises a new message only while it is active and no earlier delivery for that pin is still unacknowledged. Acknowledgement arrives as an end-of-interrupt pulse that carries a vector. Messages leave one at a time on a valid/ready handshake. When several pins are waiting, the lowest-numbered pin goes first.

Top module: `irq_router`

## Requirements
- R1: Bus offset 0x00 is the selector: a write stores bus_wdata[7:0], and a read returns the stored value in bits 7:0 with zeros above. Bus offset 0x10 is the data window onto the selected internal register. Any other offset reads zero and ignores writes.
- R2: Internal register 0x00 holds a writable 4-bit controller ID in bits 27:24. Internal register 0x01 is read-only and returns VERSION in bits 7:0 and NUM_PINS-1 in bits 23:16. Internal register 0x02 is read-only and returns ARB_ID in bits 27:24.
- R3: The entry for pin p occupies internal index 0x10+2p (low word) and 0x10+2p+1 (high word). Low word layout: vector 7:0, delivery mode 10:8, destination mode 11, pending 12, polarity 13 (1 = active low), remote-accepted 14, trigger 15 (1 = level), mask 16. High word layout: destination 31:24. After reset every entry reads zero except the mask, which is set.
- R4: Writes to read-only bits (pending, remote-accepted, registers 0x01 and 0x02) and to reserved bits have no effect. Reserved bits read zero. Any index that is not implemented, including entry slots beyond NUM_PINS, reads zero.
- R5: In edge mode, an inactive-to-active transition on an unmasked pin latches a request. The request stays latched even if the line goes inactive again. The pending bit reads 1 from the cycle after the transition until the message is accepted.
- R6: In level mode, the pending bit reads 1 while the line is active and remote-accepted is clear. Remote-accepted is set when that pin's message is accepted. It is cleared by an end-of-interrupt whose vector equals the entry's vector. An end-of-interrupt with a different vector leaves it unchanged.
- R7: The polarity bit inverts the line before edge or level detection, so with polarity 1 a low input is the active state.
- R8: While its mask bit is set, a pin issues no message. Edge transitions that occur while masked are discarded.
- R9: At most one message is outstanding. Among eligible pins the lowest-numbered one is loaded next. While msg_valid is high and msg_ready is low, every message output holds its value.
- R10: A message carries the vector, delivery mode, destination mode and destination that the pin's entry held when the message was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the bus access this cycle |
| bus_addr | input | ADDR_W | Bus offset (0x00 selector, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NUM_PINS | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | An interrupt message is offered |
| msg_ready | input | 1 | Downstream accepts the offered message |
| msg_vector | output | 8 | Message vector |
| msg_dlv | output | 3 | Message delivery mode |
| msg_dmode | output | 1 | Message destination mode |
| msg_dest | output | 8 | Message destination |

## Verification
The bench runs four families of input patterns against a behavioural model that it compares every clock. The first is a single short pulse on an edge pin, held off by msg_ready low. This separates correct latching from sampling the live line, because the pin has gone quiet before the message goes out. The second is an active-low level pin driven through acceptance and then through end-of-interrupt pulses with a wrong and a right vector. This shows whether remote-accepted really gates re-issue, and whether the vector compare is exact. The third pulses a pin while it is masked and then unmasks it, which separates a discarded edge from one that was merely deferred. The fourth pulses two pins in the same cycle, which exposes the service order and message stability under back-pressure.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int WORD_W = 32;
   localparam int VEC_W  = 8;

   localparam logic [7:0] REG_ID   = 8'h00;
   localparam logic [7:0] REG_VER  = 8'h01;
   localparam logic [7:0] REG_ARB  = 8'h02;
   localparam logic [7:0] RTE_BASE = 8'h10;
   localparam int         RTE_SLOTS = 24;

   typedef struct packed {
      logic [7:0] dest;
      logic       mask;
      logic       trig;
      logic       pol;
      logic       dmode;
      logic [2:0] dlv;
      logic [7:0] vector;
   } rte_cfg_t;

   typedef struct packed {
      logic [7:0] dest;
      logic       dmode;
      logic [2:0] dlv;
      logic [7:0] vector;
   } irq_msg_t;

   localparam rte_cfg_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                      pol: 1'b0, dmode: 1'b0, dlv: 3'd0,
                                      vector: 8'h00};

   function automatic logic [WORD_W-1:0] rte_lo_word(input rte_cfg_t c,
                                                     input logic stat,
                                                     input logic rem);
      logic [WORD_W-1:0] w;
      w        = '0;
      w[7:0]   = c.vector;
      w[10:8]  = c.dlv;
      w[11]    = c.dmode;
      w[12]    = stat;
      w[13]    = c.pol;
      w[14]    = rem;
      w[15]    = c.trig;
      w[16]    = c.mask;
      return w;
   endfunction

   function automatic irq_msg_t to_msg(input rte_cfg_t c);
      irq_msg_t m;
      m.dest   = c.dest;
      m.dmode  = c.dmode;
      m.dlv    = c.dlv;
      m.vector = c.vector;
      return m;
   endfunction

endpackage

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
   import irq_router_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  rte_cfg_t         wr_cfg,
   input  logic             eoi_valid,
   input  logic [VEC_W-1:0] eoi_vector,
   input  logic             accept,
   output rte_cfg_t         cfg,
   output logic             status,
   output logic             remote,
   output logic             eligible
);

   rte_cfg_t cfg_q;
   logic     pin_q;
   logic     pend_q;
   logic     remote_q;
   logic     act;
   logic     was_act;
   logic     edge_ok;
   logic     eoi_hit;

   assign act     = pin_in ^ cfg_q.pol;
   assign was_act = pin_q  ^ cfg_q.pol;
   assign edge_ok = act & ~was_act & ~cfg_q.mask & ~cfg_q.trig;
   assign eoi_hit = eoi_valid && (eoi_vector == cfg_q.vector);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= RTE_RESET;
      end else begin
         if (wr_lo) begin
            cfg_q.vector <= wr_cfg.vector;
            cfg_q.dlv    <= wr_cfg.dlv;
            cfg_q.dmode  <= wr_cfg.dmode;
            cfg_q.pol    <= wr_cfg.pol;
            cfg_q.trig   <= wr_cfg.trig;
            cfg_q.mask   <= wr_cfg.mask;
         end
         if (wr_hi) begin
            cfg_q.dest <= wr_cfg.dest;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q    <= 1'b0;
         pend_q   <= 1'b0;
         remote_q <= 1'b0;
      end else begin
         pin_q <= pin_in;
         if (cfg_q.trig)       pend_q <= 1'b0;
         else if (accept)      pend_q <= edge_ok;
         else if (edge_ok)     pend_q <= 1'b1;

         if (!cfg_q.trig)      remote_q <= 1'b0;
         else if (accept)      remote_q <= 1'b1;
         else if (eoi_hit)     remote_q <= 1'b0;
      end
   end

   assign cfg      = cfg_q;
   assign remote   = remote_q;
   assign status   = cfg_q.trig ? (act & ~remote_q) : pend_q;
   assign eligible = status & ~cfg_q.mask;

   assert_edge_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_ok && !wr_lo) |=> status);

   assert_remote_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (remote_q && cfg_q.trig && !eoi_valid && !wr_lo) |=> remote_q);

   assert_remote_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cfg_q.trig && !wr_lo) |=> remote_q);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_router_pkg::*;
#(
   parameter int N = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      elig,
   input  irq_msg_t [N-1:0]  cand,
   input  logic              msg_ready,
   output logic              msg_valid,
   output irq_msg_t          msg,
   output logic [N-1:0]      accept
);

   localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

   logic             pick_any;
   logic [SEL_W-1:0] pick_idx;
   logic [SEL_W-1:0] sel_q;
   logic             valid_q;
   irq_msg_t         msg_q;

   generate
      if (N == 1) begin : g_single
         assign pick_any = elig[0];
         assign pick_idx = '0;
      end else begin : g_multi
         always_comb begin
            pick_any = 1'b0;
            pick_idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (elig[i]) begin
                  pick_any = 1'b1;
                  pick_idx = SEL_W'(i);
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         sel_q   <= '0;
         msg_q   <= '0;
      end else if (valid_q) begin
         if (msg_ready) valid_q <= 1'b0;
      end else if (pick_any) begin
         valid_q <= 1'b1;
         sel_q   <= pick_idx;
         msg_q   <= cand[pick_idx];
      end
   end

   generate
      for (genvar g = 0; g < N; g++) begin : g_acc
         assign accept[g] = valid_q & msg_ready & (sel_q == SEL_W'(g));
      end
   endgenerate

   assign msg_valid = valid_q;
   assign msg       = msg_q;

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !msg_ready) |=> (valid_q && $stable(msg_q)));

   assert_one_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(accept));

   assert_progress_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_q && (|elig)) |=> valid_q);

endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int         NUM_PINS = 4,
   parameter int         ADDR_W   = 8,
   parameter logic [7:0] VERSION  = 8'h11,
   parameter logic [3:0] ARB_ID   = 4'h3
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] irq_in,
   input  logic                eoi_valid,
   input  logic [VEC_W-1:0]    eoi_vector,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [VEC_W-1:0]    msg_vector,
   output logic [2:0]          msg_dlv,
   output logic                msg_dmode,
   output logic [7:0]          msg_dest
);

   localparam logic [ADDR_W-1:0] OFS_IDX = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] OFS_WIN = ADDR_W'(8'h10);
   localparam logic [7:0]        MAX_IDX = 8'(NUM_PINS - 1);
   localparam logic [7:0]        RTE_END = 8'(16 + 2 * NUM_PINS);

   generate
      if (NUM_PINS < 1 || NUM_PINS > RTE_SLOTS) begin : g_bad_pins
         $error("irq_router: NUM_PINS must be within 1..24");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("irq_router: ADDR_W must be at least 5");
      end
   endgenerate

   logic [7:0]  idx_q;
   logic [3:0]  id_q;
   logic        sel_idx;
   logic        sel_win;
   logic        win_wr;
   logic        in_rte;
   logic [7:0]  rte_off;
   logic [6:0]  rte_pin;
   logic        rte_hi;
   rte_cfg_t    wr_cfg;
   logic        unused_wbits;

   rte_cfg_t [NUM_PINS-1:0] cfgs;
   irq_msg_t [NUM_PINS-1:0] cands;
   logic [NUM_PINS-1:0]     stat;
   logic [NUM_PINS-1:0]     rem;
   logic [NUM_PINS-1:0]     elig;
   logic [NUM_PINS-1:0]     acc;
   logic [NUM_PINS-1:0]     wr_lo;
   logic [NUM_PINS-1:0]     wr_hi;
   irq_msg_t                msg;
   logic [WORD_W-1:0]       win_data;

   assign sel_idx = (bus_addr == OFS_IDX);
   assign sel_win = (bus_addr == OFS_WIN);
   assign win_wr  = bus_wr & sel_win;

   assign in_rte  = (idx_q >= RTE_BASE) && (idx_q < RTE_END);
   assign rte_off = idx_q - RTE_BASE;
   assign rte_pin = rte_off[7:1];
   assign rte_hi  = idx_q[0];

   assign wr_cfg.vector = bus_wdata[7:0];
   assign wr_cfg.dlv    = bus_wdata[10:8];
   assign wr_cfg.dmode  = bus_wdata[11];
   assign wr_cfg.pol    = bus_wdata[13];
   assign wr_cfg.trig   = bus_wdata[15];
   assign wr_cfg.mask   = bus_wdata[16];
   assign wr_cfg.dest   = bus_wdata[31:24];
   assign unused_wbits  = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         id_q  <= '0;
      end else begin
         if (bus_wr && sel_idx) idx_q <= bus_wdata[7:0];
         if (win_wr && idx_q == REG_ID) id_q <= bus_wdata[27:24];
      end
   end

   generate
      for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
         assign wr_lo[g] = win_wr & in_rte & (rte_pin == 7'(g)) & ~rte_hi;
         assign wr_hi[g] = win_wr & in_rte & (rte_pin == 7'(g)) &  rte_hi;
         assign cands[g] = to_msg(cfgs[g]);

         irq_pin_ctrl u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_in     (irq_in[g]),
            .wr_lo      (wr_lo[g]),
            .wr_hi      (wr_hi[g]),
            .wr_cfg     (wr_cfg),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .accept     (acc[g]),
            .cfg        (cfgs[g]),
            .status     (stat[g]),
            .remote     (rem[g]),
            .eligible   (elig[g])
         );
      end
   endgenerate

   irq_arbiter #(.N(NUM_PINS)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .elig      (elig),
      .cand      (cands),
      .msg_ready (msg_ready),
      .msg_valid (msg_valid),
      .msg       (msg),
      .accept    (acc)
   );

   assign msg_vector = msg.vector;
   assign msg_dlv    = msg.dlv;
   assign msg_dmode  = msg.dmode;
   assign msg_dest   = msg.dest;

   always_comb begin
      win_data = '0;
      case (idx_q)
         REG_ID:  win_data[27:24] = id_q;
         REG_VER: begin
            win_data[7:0]   = VERSION;
            win_data[23:16] = MAX_IDX;
         end
         REG_ARB: win_data[27:24] = ARB_ID;
         default: begin
            for (int i = 0; i < NUM_PINS; i++) begin
               if (in_rte && rte_pin == 7'(i)) begin
                  if (rte_hi) win_data[31:24] = cfgs[i].dest;
                  else        win_data = rte_lo_word(cfgs[i], stat[i], rem[i]);
               end
            end
         end
      endcase
   end

   always_comb begin
      if (sel_idx)      bus_rdata = {24'h0, idx_q};
      else if (sel_win) bus_rdata = win_data;
      else              bus_rdata = '0;
   end

   assert_idx_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_idx |-> (bus_rdata[31:8] == '0));

   assert_id_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_win && idx_q == REG_ID) |-> (bus_rdata[23:0] == '0 && bus_rdata[31:28] == '0));

   assert_unimpl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_win && idx_q > REG_ARB && !in_rte) |-> (bus_rdata == '0));

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;

   localparam int NP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] irq_in = 4'b0010;
   logic        eoi_valid = 1'b0;
   logic [7:0]  eoi_vector = 8'h00;
   logic        msg_valid;
   logic        msg_ready = 1'b0;
   logic [7:0]  msg_vector;
   logic [2:0]  msg_dlv;
   logic        msg_dmode;
   logic [7:0]  msg_dest;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_router #(.NUM_PINS(NP)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dlv(msg_dlv),
      .msg_dmode(msg_dmode), .msg_dest(msg_dest)
   );

   // behavioural reference model
   bit [7:0] m_vec [NP];
   bit [2:0] m_dlv [NP];
   bit       m_dm  [NP];
   bit       m_pol [NP];
   bit       m_trg [NP];
   bit       m_msk [NP];
   bit [7:0] m_dst [NP];
   bit       m_pnd [NP];
   bit       m_rem [NP];
   bit       m_prv [NP];
   bit       mv;
   bit [7:0] mvec, mdst;
   bit [2:0] mdlv;
   bit       mdm;
   int       msel;

   always @(posedge clk) begin
      if (!rst_n) begin
         mv = 0; msel = 0; mvec = 0; mdst = 0; mdlv = 0; mdm = 0;
         for (int p = 0; p < NP; p++) begin
            m_vec[p] = 0; m_dlv[p] = 0; m_dm[p] = 0; m_pol[p] = 0; m_trg[p] = 0;
            m_msk[p] = 1; m_dst[p] = 0; m_pnd[p] = 0; m_rem[p] = 0; m_prv[p] = 0;
         end
      end else begin
         bit act [NP];
         bit elg [NP];
         bit acc [NP];
         bit eok [NP];
         for (int p = 0; p < NP; p++) begin
            act[p] = irq_in[p] ^ m_pol[p];
            elg[p] = (m_trg[p] ? (act[p] && !m_rem[p]) : m_pnd[p]) && !m_msk[p];
            acc[p] = mv && msg_ready && (msel == p);
            eok[p] = act[p] && !(m_prv[p] ^ m_pol[p]) && !m_msk[p] && !m_trg[p];
         end
         if (mv) begin
            if (msg_ready) mv = 0;
         end else begin
            for (int p = NP - 1; p >= 0; p--) begin
               if (elg[p]) begin
                  mv = 1; msel = p; mvec = m_vec[p]; mdst = m_dst[p];
                  mdlv = m_dlv[p]; mdm = m_dm[p];
               end
            end
         end
         for (int p = 0; p < NP; p++) begin
            if (m_trg[p])    m_pnd[p] = 0;
            else if (acc[p]) m_pnd[p] = eok[p];
            else if (eok[p]) m_pnd[p] = 1;
            if (!m_trg[p])   m_rem[p] = 0;
            else if (acc[p]) m_rem[p] = 1;
            else if (eoi_valid && eoi_vector == m_vec[p]) m_rem[p] = 0;
            m_prv[p] = irq_in[p];
         end
         if (bus_wr && bus_addr == 8'h10) begin
            if (u_idx >= 8'h10 && u_idx < 8'h10 + 2 * NP) begin
               int p;
               p = (u_idx - 8'h10) / 2;
               if (u_idx[0]) m_dst[p] = bus_wdata[31:24];
               else begin
                  m_vec[p] = bus_wdata[7:0];  m_dlv[p] = bus_wdata[10:8];
                  m_dm[p]  = bus_wdata[11];   m_pol[p] = bus_wdata[13];
                  m_trg[p] = bus_wdata[15];   m_msk[p] = bus_wdata[16];
               end
            end
         end
         if (bus_wr && bus_addr == 8'h00) u_idx = bus_wdata[7:0];
      end
   end

   bit [7:0] u_idx = 8'h00;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // per-cycle comparison of the message channel with the model (R9, R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9 msg_valid vs model", {31'h0, msg_valid}, {31'h0, mv});
         if (mv && msg_valid)
            chk("R10 message fields vs model",
                {9'h0, msg_dest, msg_dlv, msg_dmode, msg_vector},
                {9'h0, mdst, mdlv, mdm, mvec});
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rdl(input logic [7:0] a, input string tag, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(input logic [NP-1:0] bits);
      irq_in = irq_in | bits;
      @(negedge clk);
      irq_in = irq_in & ~bits;
   endtask

   task automatic eoi(input logic [7:0] v);
      eoi_valid = 1'b1; eoi_vector = v;
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R9 reset msg_valid", {31'h0, msg_valid}, 32'h0);
      rdl(8'h00, "R1 selector reset", 32'h0);
      rdl(8'h10, "R2 ID reset", 32'h0);
      // identification registers
      wr(8'h00, 32'hFFFF_FF01);
      rdl(8'h00, "R1 selector low byte only", 32'h0000_0001);
      rdl(8'h10, "R2 version and max index", 32'h0003_0011);
      wr(8'h00, 32'h02);
      wr(8'h10, 32'hFFFF_FFFF);
      rdl(8'h10, "R4 arbitration reg read-only", 32'h0300_0000);
      wr(8'h00, 32'h00);
      wr(8'h10, 32'hFFFF_FFFF);
      rdl(8'h10, "R2 R4 ID writable, reserved zero", 32'h0F00_0000);
      // entry reset values
      wr(8'h00, 32'h10);
      rdl(8'h10, "R3 entry low reset masked", 32'h0001_0000);
      wr(8'h00, 32'h17);
      rdl(8'h10, "R3 last entry high reset", 32'h0);
      wr(8'h00, 32'h18);
      wr(8'h10, 32'hFFFF_FFFF);
      rdl(8'h10, "R4 slot beyond pins reads zero", 32'h0);
      wr(8'h00, 32'h05);
      rdl(8'h10, "R4 unimplemented index", 32'h0);
      wr(8'h04, 32'h0000_0033);
      rdl(8'h04, "R1 other offset reads zero", 32'h0);
      rdl(8'h00, "R1 other offset write ignored", 32'h0000_0005);

      // edge pin 0
      wr(8'h00, 32'h10);
      wr(8'h10, 32'hFFFE_5031);
      rdl(8'h10, "R4 read-only and reserved bits ignored", 32'h0000_0031);
      wr(8'h00, 32'h11);
      wr(8'h10, 32'hA5FF_FFFF);
      rdl(8'h10, "R3 destination byte", 32'hA500_0000);
      wr(8'h00, 32'h10);
      pulse(4'b0001);
      @(negedge clk);
      rdl(8'h10, "R5 pending after short pulse", 32'h0000_1031);
      chk("R5 message offered after pulse", {31'h0, msg_valid}, 32'h1);
      chk("R10 edge message", {16'h0, msg_dest, msg_vector}, 32'h0000_A531);
      idle(3);
      chk("R9 held under back-pressure", {24'h0, msg_vector}, 32'h31);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
      rdl(8'h10, "R5 pending cleared on accept", 32'h0000_0031);
      idle(3);
      chk("R5 no reissue after accept", {31'h0, msg_valid}, 32'h0);

      // level pin 1, active low
      wr(8'h00, 32'h13);
      wr(8'h10, 32'h0700_0000);
      wr(8'h00, 32'h12);
      wr(8'h10, 32'h0000_AC42);
      idle(2);
      chk("R7 high line inactive when active-low", {31'h0, msg_valid}, 32'h0);
      irq_in[1] = 1'b0;
      @(negedge clk);
      chk("R10 level message fields", {9'h0, msg_dest, msg_dlv, msg_dmode, msg_vector},
          {9'h0, 8'h07, 3'd4, 1'b1, 8'h42});
      msg_ready = 1'b1;
      idle(4);
      rdl(8'h10, "R6 remote set, no pending", 32'h0000_EC42);
      chk("R6 no reissue while remote set", {31'h0, msg_valid}, 32'h0);
      msg_ready = 1'b0;
      eoi(8'h43);
      idle(2);
      rdl(8'h10, "R6 wrong-vector EOI ignored", 32'h0000_EC42);
      eoi(8'h42);
      @(negedge clk);
      rdl(8'h10, "R6 EOI clears remote, line still active", 32'h0000_BC42);
      chk("R6 reissue after EOI", {24'h0, msg_vector}, 32'h42);
      irq_in[1] = 1'b1;
      msg_ready = 1'b1;
      idle(3);
      msg_ready = 1'b0;
      eoi(8'h42);
      idle(2);
      rdl(8'h10, "R6 R7 idle after EOI with inactive line", 32'h0000_AC42);
      chk("R7 no message when line high", {31'h0, msg_valid}, 32'h0);

      // masked edge pin 2
      wr(8'h00, 32'h14);
      wr(8'h10, 32'h0001_0055);
      pulse(4'b0100);
      idle(3);
      chk("R8 masked pin silent", {31'h0, msg_valid}, 32'h0);
      rdl(8'h10, "R8 masked edge not latched", 32'h0001_0055);
      wr(8'h10, 32'h0000_0055);
      idle(3);
      chk("R8 discarded edge after unmask", {31'h0, msg_valid}, 32'h0);

      // priority: pins 0 and 3 together
      wr(8'h00, 32'h16);
      wr(8'h10, 32'h0000_0066);
      pulse(4'b1001);
      idle(3);
      chk("R9 lowest pin first", {24'h0, msg_vector}, 32'h31);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
      idle(2);
      chk("R9 second pin follows", {24'h0, msg_vector}, 32'h66);
      chk("R9 second message valid", {31'h0, msg_valid}, 32'h1);
      msg_ready = 1'b1;
      idle(3);
      chk("R9 drained", {31'h0, msg_valid}, 32'h0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule